// File: doc/BRIEF.md
# Write-one-to-clear interrupt aggregator

This block gathers a set of interrupt sources into one status register and turns them into a single level interrupt for the CPU. Each source is an event input. A pulse on it sets the matching status bit, and software clears the bit by writing a one to it. A mask register selects which status bits count as pending. A one-bit enable gates the final interrupt line. A combinational dispatch vector names the lowest-numbered pending source, so the handler can service one source per pass. When nothing is pending, a spurious flag is raised instead.

The source layout follows the data-movement engine around the block:
- Inbound descriptor-chain events sit at bits 0 to 3: complete, ok, error and end-of-list.
- Outbound events use bits 4 to 7, in the same order.
- Inbound out-of-descriptors is bit 9.
- The external device interrupt is bit 25. It is fed by a level input.
- A bus-abort event is bit 26.

The block does not care what a bit means, only where it sits. Besides the register port, a mask-and-acknowledge command masks a source and clears its status in a single cycle. An unmask command re-enables a source without touching its status.

Top module: `irq_gather`

## Requirements
- R1: After reset, the status, mask and enable registers all read 0. `irq_o` is low, `spurious_o` is high and `vec_o` is 0.
- R2: A write to byte offset 0x0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R3: A high bit of `evt_i` sets the matching status bit at the next clock edge. If a clear (a register write or a mask-and-acknowledge) hits the same bit in the same cycle, the set wins.
- R4: While `ext_lvl_i` is high, status bit 25 is set at every clock edge, so a clear cannot leave it low. Once the input is low, bit 25 clears like any other bit.
- R5: Pending is status AND mask. `vec_o` is the index of the lowest pending bit. With no pending bit, `spurious_o` is 1 and `vec_o` is 0. The enable bit has no effect on `vec_o` or `spurious_o`.
- R6: `irq_o` is high exactly when the enable bit is 1 and at least one bit is pending. A write to offset 0x8 stores only write-data bit 0. The enable register reads back with bits 31..1 as 0.
- R7: A write to offset 0x4 loads the whole mask register from the write data.
- R8: Mask-and-acknowledge (`mack_v_i` with index `mack_idx_i`) clears that mask bit and that status bit at the same edge. For that bit it overrides a same-cycle mask write and a same-cycle unmask.
- R9: Unmask (`unmask_v_i` with index `unmask_idx_i`) sets only that mask bit. Status is left unchanged.
- R10: Register selection uses address bits 3..2, and address bits 1..0 are ignored. Offset 0xC reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| ext_lvl_i | input | 1 | Level-sensitive external interrupt, feeds bit 25 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| mack_v_i | input | 1 | Mask-and-acknowledge command valid |
| mack_idx_i | input | 5 | Source index for mask-and-acknowledge |
| unmask_v_i | input | 1 | Unmask command valid |
| unmask_idx_i | input | 5 | Source index for unmask |
| irq_o | output | 1 | Single level interrupt to the CPU |
| vec_o | output | 5 | Lowest pending source index |
| spurious_o | output | 1 | High when no source is pending |

## Verification
The critical overlap is an event pulse and a clear landing on the same status bit in the same clock.

The bench provokes it for every one of the 32 bits in two ways:
- It drives a pulse together with a write-one-to-clear of that bit.
- It drives a pulse together with a mask-and-acknowledge of that bit.

In both cases it expects the status bit to remain set while the mask bit still follows the command.

A second overlap pits mask-and-acknowledge against a full mask write and against an unmask of the same index. The acknowledge must win for its own bit and leave every other bit as the write specified.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;

    // Register selector, decoded from address bits 3..2.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Source positions used by the surrounding logic.
    localparam int SRC_IN_DONE   = 0;
    localparam int SRC_IN_OK     = 1;
    localparam int SRC_IN_ERR    = 2;
    localparam int SRC_IN_EOL    = 3;
    localparam int SRC_OUT_DONE  = 4;
    localparam int SRC_OUT_OK    = 5;
    localparam int SRC_OUT_ERR   = 6;
    localparam int SRC_OUT_EOL   = 7;
    localparam int SRC_IN_NODESC = 9;
    localparam int SRC_EXT       = 25;
    localparam int SRC_ABORT     = 26;

    // Word index (byte address shifted right by two) to register selector.
    function automatic reg_sel_e sel_of(input logic [31:0] word);
        if (word == 32'd0)      return SEL_STATUS;
        else if (word == 32'd1) return SEL_MASK;
        else if (word == 32'd2) return SEL_ENABLE;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/irqg_status.sv
`timescale 1ns/1ps
module irqg_status #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  set_i,
    input  logic [NSRC-1:0]  w1c_i,
    input  logic             ack_v_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic [NSRC-1:0]  status_o
);

    typedef struct packed {
        logic [NSRC-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] clr;

    always_comb begin
        clr = w1c_i;
        if (ack_v_i) begin
            clr[ack_idx_i] = 1'b1;
        end
        // Clears apply first, then sets, so a same-cycle set wins.
        st_d.bits = (st_q.bits & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

endmodule

// File: rtl/irqg_ctrl.sv
`timescale 1ns/1ps
module irqg_ctrl #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mask_we_i,
    input  logic [NSRC-1:0]  mask_wdata_i,
    input  logic             en_we_i,
    input  logic             en_wdata_i,
    input  logic             unmask_v_i,
    input  logic [IDX_W-1:0] unmask_idx_i,
    input  logic             ack_v_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic [NSRC-1:0]  mask_o,
    output logic             en_o
);

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic            en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (mask_we_i) begin
            ctl_d.mask = mask_wdata_i;
        end
        if (unmask_v_i) begin
            ctl_d.mask[unmask_idx_i] = 1'b1;
        end
        // Acknowledge is applied last and wins for its own bit.
        if (ack_v_i) begin
            ctl_d.mask[ack_idx_i] = 1'b0;
        end
        if (en_we_i) begin
            ctl_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mask_o = ctl_q.mask;
    assign en_o   = ctl_q.en;

endmodule

// File: rtl/irqg_prio.sv
`timescale 1ns/1ps
module irqg_prio #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pending_i,
    output logic [IDX_W-1:0] vec_o,
    output logic             none_o
);

    // below_q[i]: some pending bit lies strictly below position i.
    logic [NSRC-1:0] below;
    logic [NSRC-1:0] first;

    assign below[0] = 1'b0;
    for (genvar g = 1; g < NSRC; g++) begin : g_chain
        assign below[g] = below[g-1] | pending_i[g-1];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_first
        assign first[g] = pending_i[g] & ~below[g];
    end

    // first is one-hot or zero, so an OR of the indices encodes it.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first[i]) begin
                vec_o = vec_o | IDX_W'(i);
            end
        end
    end

    assign none_o = ~|pending_i;

endmodule

// File: rtl/irq_gather.sv
`timescale 1ns/1ps
module irq_gather
    import irqg_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int AW      = 4,
    parameter int EXT_BIT = SRC_EXT,
    parameter int IDX_W   = $clog2(NSRC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  evt_i,
    input  logic             ext_lvl_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [NSRC-1:0]  wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [NSRC-1:0]  rd_data_o,
    input  logic             mack_v_i,
    input  logic [IDX_W-1:0] mack_idx_i,
    input  logic             unmask_v_i,
    input  logic [IDX_W-1:0] unmask_idx_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] vec_o,
    output logic             spurious_o
);

    reg_sel_e        wr_sel, rd_sel;
    logic [NSRC-1:0] set_w, w1c_w, status_w, mask_w, pend_w;
    logic            en_w;

    assign wr_sel = sel_of(32'(wr_addr_i) >> 2);
    assign rd_sel = sel_of(32'(rd_addr_i) >> 2);

    // Event set vector: the external level is folded in at its own bit.
    for (genvar b = 0; b < NSRC; b++) begin : g_set
        if (b == EXT_BIT) begin : g_ext
            assign set_w[b] = evt_i[b] | ext_lvl_i;
        end else begin : g_evt
            assign set_w[b] = evt_i[b];
        end
    end

    assign w1c_w = (wr_en_i && wr_sel == SEL_STATUS) ? wr_data_i : '0;

    irqg_status #(.NSRC(NSRC), .IDX_W(IDX_W)) status_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_w),
        .w1c_i     (w1c_w),
        .ack_v_i   (mack_v_i),
        .ack_idx_i (mack_idx_i),
        .status_o  (status_w)
    );

    irqg_ctrl #(.NSRC(NSRC), .IDX_W(IDX_W)) ctrl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mask_we_i    (wr_en_i && wr_sel == SEL_MASK),
        .mask_wdata_i (wr_data_i),
        .en_we_i      (wr_en_i && wr_sel == SEL_ENABLE),
        .en_wdata_i   (wr_data_i[0]),
        .unmask_v_i   (unmask_v_i),
        .unmask_idx_i (unmask_idx_i),
        .ack_v_i      (mack_v_i),
        .ack_idx_i    (mack_idx_i),
        .mask_o       (mask_w),
        .en_o         (en_w)
    );

    assign pend_w = status_w & mask_w;

    irqg_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) prio_i (
        .pending_i (pend_w),
        .vec_o     (vec_o),
        .none_o    (spurious_o)
    );

    assign irq_o = en_w & ~spurious_o;

    always_comb begin
        case (rd_sel)
            SEL_STATUS: rd_data_o = status_w;
            SEL_MASK:   rd_data_o = mask_w;
            SEL_ENABLE: rd_data_o = NSRC'(en_w);
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_gather_chk.sv
`timescale 1ns/1ps
module irq_gather_chk #(
    parameter int NSRC    = 32,
    parameter int AW      = 4,
    parameter int EXT_BIT = 25,
    parameter int IDX_W   = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NSRC-1:0]  evt_i,
    input logic             ext_lvl_i,
    input logic             wr_en_i,
    input logic [AW-1:0]    wr_addr_i,
    input logic [NSRC-1:0]  wr_data_i,
    input logic             mack_v_i,
    input logic [IDX_W-1:0] mack_idx_i,
    input logic             unmask_v_i,
    input logic [IDX_W-1:0] unmask_idx_i,
    input logic [NSRC-1:0]  status_i,
    input logic [NSRC-1:0]  mask_i,
    input logic             en_i,
    input logic             irq_o,
    input logic [IDX_W-1:0] vec_o,
    input logic             spurious_o
);

    logic [NSRC-1:0] setv, pend;
    logic            st_wr;

    always_comb begin
        setv          = evt_i;
        setv[EXT_BIT] = evt_i[EXT_BIT] | ext_lvl_i;
    end
    assign pend  = status_i & mask_i;
    assign st_wr = wr_en_i && ((32'(wr_addr_i) >> 2) == 32'd0);

    // R2
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_wr |=> ((status_i & $past(wr_data_i) & ~$past(setv)) == '0));

    // R3
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|setv) |=> ((status_i & $past(setv)) == $past(setv)));

    // R4
    ext_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_lvl_i |=> status_i[EXT_BIT]);

    // R5
    vec_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !spurious_o |-> (pend[vec_o] &&
            ((pend & ((NSRC'(1) << vec_o) - NSRC'(1))) == '0)));

    // R5
    spurious_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spurious_o |-> (vec_o == '0 && !irq_o));

    // R6
    enable_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !irq_o);

    // R8
    mack_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mack_v_i |=> (!mask_i[$past(mack_idx_i)] &&
            (status_i[$past(mack_idx_i)] == $past(setv[mack_idx_i]))));

    // R9
    unmask_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unmask_v_i && !(mack_v_i && mack_idx_i == unmask_idx_i))
            |=> mask_i[$past(unmask_idx_i)]);

endmodule

bind irq_gather irq_gather_chk #(
    .NSRC(NSRC), .AW(AW), .EXT_BIT(EXT_BIT), .IDX_W(IDX_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt_i),
    .ext_lvl_i    (ext_lvl_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .mack_v_i     (mack_v_i),
    .mack_idx_i   (mack_idx_i),
    .unmask_v_i   (unmask_v_i),
    .unmask_idx_i (unmask_idx_i),
    .status_i     (status_w),
    .mask_i       (mask_w),
    .en_i         (en_w),
    .irq_o        (irq_o),
    .vec_o        (vec_o),
    .spurious_o   (spurious_o)
);

// File: tb/irq_gather_tb_top.sv
`timescale 1ns/1ps
module irq_gather_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        ext = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mack_v = 1'b0;
    logic [4:0]  mack_idx = '0;
    logic        unmask_v = 1'b0;
    logic [4:0]  unmask_idx = '0;
    logic        irq;
    logic [4:0]  vec;
    logic        spurious;

    logic [31:0] m_status = '0;
    logic [31:0] m_mask = '0;
    logic        m_en = 1'b0;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  summarised = 1'b0;

    always #2.5 clk = ~clk;

    irq_gather dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ext_lvl_i(ext),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .mack_v_i(mack_v), .mack_idx_i(mack_idx),
        .unmask_v_i(unmask_v), .unmask_idx_i(unmask_idx),
        .irq_o(irq), .vec_o(vec), .spurious_o(spurious)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Compare every register and output against the model.
    task automatic check_all(input string tag);
        logic [31:0] p;
        logic [4:0]  ev;
        p  = m_status & m_mask;
        ev = '0;
        for (int i = 31; i >= 0; i--) if (p[i]) ev = 5'(i);
        rd_addr = 4'h0; #0.2; chk({tag, " status"}, rd_data, m_status);
        rd_addr = 4'h5; #0.2; chk({tag, " mask R10"}, rd_data, m_mask);
        rd_addr = 4'h8; #0.2; chk({tag, " enable R6"}, rd_data, {31'b0, m_en});
        rd_addr = 4'hC; #0.2; chk({tag, " hole R10"}, rd_data, 32'h0);
        chk({tag, " vec R5"}, {27'b0, vec}, {27'b0, ev});
        chk({tag, " spurious R5"}, {31'b0, spurious}, {31'b0, (p == 0)});
        chk({tag, " irq R6"}, {31'b0, irq}, {31'b0, m_en && (p != 0)});
    endtask

    // One clock: model update from the driven inputs, then drop strobes.
    task automatic tick();
        logic [31:0] setv, clr;
        @(posedge clk);
        setv = evt | (ext ? 32'h0200_0000 : 32'h0);
        clr  = (wr_en && wr_addr[3:2] == 2'd0) ? wr_data : 32'h0;
        if (mack_v) clr = clr | (32'h1 << mack_idx);
        m_status = (m_status & ~clr) | setv;
        if (wr_en && wr_addr[3:2] == 2'd1) m_mask = wr_data;
        if (unmask_v) m_mask = m_mask | (32'h1 << unmask_idx);
        if (mack_v) m_mask = m_mask & ~(32'h1 << mack_idx);
        if (wr_en && wr_addr[3:2] == 2'd2) m_en = wr_data[0];
        @(negedge clk);
        evt = '0; wr_en = 1'b0; mack_v = 1'b0; unmask_v = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic finish_run();
        if (!summarised) begin
            summarised = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R6: only bit 0 of the enable register is kept
        wr(4'h8, 32'hFFFF_FFFE); check_all("R6 en bit0 only");
        wr(4'h9, 32'h0000_0001); check_all("R10 low addr bits ignored");
        wr(4'h4, 32'hFFFF_FFFF); check_all("R7 mask load");

        // R3 / R2 sweep over every bit
        for (int i = 0; i < 32; i++) begin
            evt = 32'h1 << i; tick(); check_all("R3 set");
            wr(4'h0, ~(32'h1 << i)); check_all("R2 zero keeps");
            wr(4'h0, 32'h1 << i); check_all("R2 one clears");
        end

        // R5 lowest-bit priority over all pairs
        for (int i = 0; i < 32; i++) begin
            for (int j = i; j < 32; j++) begin
                evt = (32'h1 << i) | (32'h1 << j); tick();
                check_all("R5 pair");
                wr(4'h0, 32'hFFFF_FFFF);
            end
        end

        // R5 mask gating
        wr(4'h4, 32'h0000_00F0);
        evt = 32'h0600_020F; tick(); check_all("R5 masked out");
        evt = 32'h0000_0020; tick(); check_all("R5 masked in");
        wr(4'h0, 32'hFFFF_FFFF); wr(4'h4, 32'hFFFF_FFFF);

        // R6 enable gating, dispatch unaffected
        wr(4'h8, 32'h0);
        evt = 32'h0400_0000; tick(); check_all("R6 disabled");
        wr(4'h8, 32'h1); check_all("R6 enabled");
        wr(4'h0, 32'hFFFF_FFFF);

        // R3 set wins against same-cycle clear write
        for (int i = 0; i < 32; i++) begin
            evt = 32'h1 << i; wr(4'h0, 32'h1 << i); check_all("R3 set beats w1c");
            wr(4'h0, 32'h1 << i); check_all("R2 clear after collision");
        end

        // R4 external level
        ext = 1'b1; tick(); check_all("R4 level sets");
        wr(4'h0, 32'h0200_0000); check_all("R4 clear while high");
        ext = 1'b0; tick(); check_all("R4 held after drop");
        wr(4'h0, 32'h0200_0000); check_all("R4 clear when low");

        // R8 / R9 sweep
        for (int i = 0; i < 32; i++) begin
            evt = 32'h1 << i; tick();
            mack_v = 1'b1; mack_idx = 5'(i); tick(); check_all("R8 mask-ack");
            evt = 32'h1 << i; tick();
            unmask_v = 1'b1; unmask_idx = 5'(i); tick(); check_all("R9 unmask");
            evt = 32'h1 << i; mack_v = 1'b1; mack_idx = 5'(i); tick();
            check_all("R8 ack vs event");
            wr(4'h4, 32'hFFFF_FFFF); wr(4'h0, 32'hFFFF_FFFF);
        end

        // R8 against mask write and unmask on the same index
        mack_v = 1'b1; mack_idx = 5'd3; wr(4'h4, 32'hFFFF_FFFF);
        check_all("R8 ack beats mask write");
        mack_v = 1'b1; mack_idx = 5'd17; unmask_v = 1'b1; unmask_idx = 5'd17; tick();
        check_all("R8 ack beats unmask");

        // R10 hole offset ignored
        evt = 32'h0000_0041; tick();
        wr(4'hC, 32'hFFFF_FFFF); check_all("R10 hole write");

        done = 1'b1;
        finish_run();
    end

endmodule